// File: doc/BRIEF.md
# Extended-Precision Value Classifier

This unit inspects one 80-bit extended-precision register value together with the tag bit that says whether the register is empty. It reports the value's class as a 4-bit condition code. The code has a class field in bits C3, C2 and C0, and bit C1 carries the sign. The classes are empty, zero, denormal, normal, infinity, NaN and unsupported encoding. The operation raises no exceptions, so the code is the only result.

The unit has one register stage. A request is presented with `in_valid`, and the code appears one cycle later qualified by `out_valid`. The code stays unchanged on cycles with no request. The classification logic is split in two steps. The first step reduces the exponent and significand to a handful of field flags. The second step maps those flags to a class, and a package function turns the class into the condition code.

Top module: `fpx_classifier`

## Requirements
- R1: During and straight after synchronous reset `out_valid` is 0 and `out_cc` is 4'b0000.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_cc` takes its new value on that same edge. `out_cc` holds its value across cycles with `in_valid` low.
- R3: With `in_empty` = 1, C3,C2,C0 = 1,0,1 whatever the value bits hold. The code bits are `out_cc[3]`=C3, `out_cc[2]`=C2, `out_cc[1]`=C1, `out_cc[0]`=C0.
- R4: Exponent `in_value[78:64]` all zero and significand `in_value[63:0]` all zero gives C3,C2,C0 = 1,0,0.
- R5: Exponent zero with a nonzero significand gives C3,C2,C0 = 1,1,0. This covers a set integer bit `in_value[63]` (pseudo-denormal) as well as a clear one.
- R6: Exponent neither zero nor all ones, with the integer bit set, gives C3,C2,C0 = 0,1,0.
- R7: Exponent all ones, integer bit set and fraction `in_value[62:0]` zero gives C3,C2,C0 = 0,1,1.
- R8: Exponent all ones, integer bit set and nonzero fraction gives C3,C2,C0 = 0,0,1. Quiet and signalling NaNs are treated alike.
- R9: Nonzero exponent with the integer bit clear gives C3,C2,C0 = 0,0,0. This includes pseudo-infinity and pseudo-NaN.
- R10: C1 equals the sign bit `in_value[79]` for every class, including empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_empty | input | 1 | Register tag: 1 means the register is empty |
| in_value | input | 80 | Sign, 15-bit exponent, 64-bit significand with explicit integer bit |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_cc | output | 4 | Condition code {C3,C2,C1,C0} |

## Verification
Each class is driven with both signs, so a C1 error cannot hide behind a class that happens to share the bit. The patterns are chosen in pairs that differ only at a class boundary. Zero is paired with a smallest denormal, a denormal with a pseudo-denormal, infinity with quiet and signalling NaNs, and infinity and NaN with their integer-bit-clear twins. A normal value is paired with an unnormal at the same exponent. Empty registers are given value bits that would otherwise read as normal or NaN, to show the tag wins. Idle cycles with changing value bits show that the code holds, and back-to-back requests show that each one gets its own code.

// File: rtl/fpx_class_pkg.sv
package fpx_class_pkg;

    parameter int EXP_W_DEF = 15;
    parameter int MAN_W_DEF = 64;

    // Field summary; width independent so any exponent/significand split maps to it.
    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic int_bit;
        logic frac_zero;
    } fpx_fields_t;

    typedef enum logic [2:0] {
        CLS_EMPTY  = 3'd0,
        CLS_ZERO   = 3'd1,
        CLS_DENORM = 3'd2,
        CLS_NORMAL = 3'd3,
        CLS_INF    = 3'd4,
        CLS_NAN    = 3'd5,
        CLS_UNSUP  = 3'd6
    } fpx_class_t;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } fpx_cc_t;

    function automatic fpx_cc_t class_to_cc(input fpx_class_t cls, input logic sign);
        fpx_cc_t cc;
        cc.c1 = sign;
        case (cls)
            CLS_EMPTY:  {cc.c3, cc.c2, cc.c0} = 3'b101;
            CLS_ZERO:   {cc.c3, cc.c2, cc.c0} = 3'b100;
            CLS_DENORM: {cc.c3, cc.c2, cc.c0} = 3'b110;
            CLS_NORMAL: {cc.c3, cc.c2, cc.c0} = 3'b010;
            CLS_INF:    {cc.c3, cc.c2, cc.c0} = 3'b011;
            CLS_NAN:    {cc.c3, cc.c2, cc.c0} = 3'b001;
            default:    {cc.c3, cc.c2, cc.c0} = 3'b000;
        endcase
        return cc;
    endfunction

endpackage

// File: rtl/fpx_field_split.sv
module fpx_field_split
    import fpx_class_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int MAN_W = MAN_W_DEF
) (
    input  logic [EXP_W+MAN_W:0] value,
    output fpx_fields_t          fields
);
    localparam int SIGN_POS = EXP_W + MAN_W;
    localparam int INT_POS  = MAN_W - 1;
    localparam int FRAC_W   = MAN_W - 1;

    logic [EXP_W-1:0]  exp_bits;
    logic [FRAC_W-1:0] frac_bits;

    assign exp_bits  = value[SIGN_POS-1:MAN_W];
    assign frac_bits = value[FRAC_W-1:0];

    always_comb begin
        fields.sign      = value[SIGN_POS];
        fields.exp_zero  = (exp_bits == '0);
        fields.exp_ones  = &exp_bits;
        fields.int_bit   = value[INT_POS];
        fields.frac_zero = (frac_bits == '0);
    end
endmodule

// File: rtl/fpx_class_decide.sv
module fpx_class_decide
    import fpx_class_pkg::*;
(
    input  logic        empty,
    input  fpx_fields_t fields,
    output fpx_class_t  cls
);
    always_comb begin
        if (empty) begin
            cls = CLS_EMPTY;
        end else if (fields.exp_zero) begin
            // exponent zero: zero only if the whole significand is clear
            if (!fields.int_bit && fields.frac_zero) cls = CLS_ZERO;
            else                                     cls = CLS_DENORM;
        end else if (!fields.int_bit) begin
            cls = CLS_UNSUP;
        end else if (fields.exp_ones) begin
            cls = fields.frac_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/fpx_classifier.sv
module fpx_classifier
    import fpx_class_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int MAN_W = MAN_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_empty,
    input  logic [EXP_W+MAN_W:0] in_value,
    output logic                 out_valid,
    output logic [3:0]           out_cc
);
    localparam int SIGN_POS = EXP_W + MAN_W;

    fpx_fields_t fields;
    fpx_class_t  cls;
    fpx_cc_t     cc_next;
    fpx_cc_t     cc_q;

    fpx_field_split #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_split (
        .value  (in_value),
        .fields (fields)
    );

    fpx_class_decide u_decide (
        .empty  (in_empty),
        .fields (fields),
        .cls    (cls)
    );

    assign cc_next = class_to_cc(cls, fields.sign);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cc_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cc_q <= cc_next;
        end
    end

    assign out_cc = cc_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!in_valid) && $past(!rst)) |-> $stable(out_cc)); // R2

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !rst) |-> out_cc[1] == $past(in_value[SIGN_POS])); // R10

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_empty && !rst) |-> (out_cc[3] && !out_cc[2] && out_cc[0])); // R3

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst)
        !(out_cc[3] && out_cc[2] && out_cc[0])); // R5
endmodule

// File: tb/fpx_classifier_bench.sv
module fpx_classifier_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_empty;
    logic [79:0] in_value;
    logic        out_valid;
    logic [3:0]  out_cc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fpx_classifier u_fpx_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_empty(in_empty),
        .in_value(in_value), .out_valid(out_valid), .out_cc(out_cc)
    );

    function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
        return {s, e, m};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got valid/cc=%b expected %b", req, act, exp);
        end
    endtask

    // one request; inputs change on negedge, result sampled one negedge later
    task automatic classify(input string req, input logic emp, input logic [79:0] v,
                            input logic [3:0] exp_cc);
        @(negedge clk);
        in_valid = 1'b1; in_empty = emp; in_value = v;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, out_cc}, {1'b1, exp_cc});
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_empty = 1'b0; in_value = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {out_valid, out_cc}, 5'b0_0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_cc}, 5'b0_0000);
    endtask

    task automatic t_zero();
        classify("R4 +zero", 1'b0, mk(0, 15'h0, 64'h0), 4'b1000);
        classify("R4 R10 -zero", 1'b0, mk(1, 15'h0, 64'h0), 4'b1010);
    endtask

    task automatic t_denorm();
        classify("R5 min denormal", 1'b0, mk(0, 15'h0, 64'h1), 4'b1100);
        classify("R5 R10 pseudo-denormal", 1'b0, mk(1, 15'h0, 64'h8000_0000_0000_0001), 4'b1110);
        classify("R5 pseudo-denormal bare int bit", 1'b0, mk(0, 15'h0, 64'h8000_0000_0000_0000), 4'b1100);
    endtask

    task automatic t_normal();
        classify("R6 one", 1'b0, mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 4'b0100);
        classify("R6 R10 smallest normal neg", 1'b0, mk(1, 15'h0001, 64'h8000_0000_0000_0000), 4'b0110);
        classify("R6 largest normal", 1'b0, mk(0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF), 4'b0100);
    endtask

    task automatic t_inf_nan();
        classify("R7 +inf", 1'b0, mk(0, 15'h7FFF, 64'h8000_0000_0000_0000), 4'b0101);
        classify("R7 R10 -inf", 1'b0, mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), 4'b0111);
        classify("R8 quiet nan", 1'b0, mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), 4'b0001);
        classify("R8 R10 signalling nan", 1'b0, mk(1, 15'h7FFF, 64'h8000_0000_0000_0001), 4'b0011);
    endtask

    task automatic t_unsup();
        classify("R9 pseudo-nan", 1'b0, mk(0, 15'h7FFF, 64'h0000_0000_0000_0001), 4'b0000);
        classify("R9 R10 pseudo-inf", 1'b0, mk(1, 15'h7FFF, 64'h0), 4'b0010);
        classify("R9 unnormal", 1'b0, mk(0, 15'h3FFF, 64'h4000_0000_0000_0000), 4'b0000);
    endtask

    task automatic t_empty();
        classify("R3 R10 empty over normal", 1'b1, mk(1, 15'h3FFF, 64'h8000_0000_0000_0000), 4'b1011);
        classify("R3 empty over nan", 1'b1, mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), 4'b1001);
        classify("R3 empty over zero", 1'b1, mk(0, 15'h0, 64'h0), 4'b1001);
    endtask

    task automatic t_hold_and_stream();
        classify("R2 setup", 1'b0, mk(0, 15'h7FFF, 64'h8000_0000_0000_0000), 4'b0101);
        // idle cycles with new value bits: code holds, strobe low
        in_value = mk(1, 15'h0, 64'h1);
        in_empty = 1'b1;
        @(negedge clk);
        check("R2 hold idle 1", {out_valid, out_cc}, 5'b0_0101);
        in_value = mk(0, 15'h1234, 64'h0);
        @(negedge clk);
        check("R2 hold idle 2", {out_valid, out_cc}, 5'b0_0101);
        // back-to-back requests
        in_valid = 1'b1; in_empty = 1'b0; in_value = mk(1, 15'h0, 64'h0);
        @(negedge clk);
        check("R2 stream 1", {out_valid, out_cc}, 5'b1_1010);
        in_value = mk(0, 15'h4000, 64'h8000_0000_0000_0000);
        @(negedge clk);
        check("R2 stream 2", {out_valid, out_cc}, 5'b1_0100);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 stream end", {out_valid, out_cc}, 5'b0_0100);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_denorm();
        t_normal();
        t_inf_nan();
        t_unsup();
        t_empty();
        t_hold_and_stream();
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule